// File: doc/BRIEF.md
# Battery Voltage Calibration Datapath

This block converts a 10-bit unsigned battery-voltage ADC code into a calibrated reading. The reading has two parts: a signed whole number of millivolts, and a signed fraction expressed in millionths of a millivolt. Two signed 4-bit trims come in packed in one calibration byte and are held in a register. One is a zero-scale offset and the other is a gain error.

For each sample, the offset trim is subtracted from the raw code first. A gain correction is then applied in steps of 0.0015, and the corrected count is scaled by the LSB weight of 4.6875 mV. Every division truncates toward zero, so a negative intermediate produces a non-positive fraction.

The arithmetic runs in a three-stage pipeline that accepts one sample per cycle. A result appears with a valid flag exactly three cycles after its sample.

Top module: `vbat_cal_top`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and both outputs are 0. Both trims reset to 0, so a raw code R then yields mV = (R*46875)/10000.
- R2: When `cal_load` is 1, `cal_byte` is captured. Bits 3:0 hold the gain trim GE and bits 7:4 hold the offset trim Z. Each is a two's-complement value from -8 to 7.
- R3: The offset-corrected count is A = raw − Z, and it is computed before any scaling.
- R4: The gain-corrected count is C = (A × (10000 − 15·GE)) / 10000, using integer division truncated toward zero.
- R5: With M = C × 46875, `out_mv` = M / 10000 and `out_frac` = (M mod 10000) × 100. `out_frac` always lies strictly between −1,000,000 and 1,000,000.
- R6: Division and modulo truncate toward zero. A negative M gives `out_mv` ≤ 0 and `out_frac` ≤ 0, and a positive `out_mv` never comes with a negative `out_frac`.
- R7: `out_valid` is 1 exactly three clock cycles after the cycle in which `in_valid` was 1. Back-to-back samples produce back-to-back results in order.
- R8: A sample presented in the same cycle as `cal_load` uses the previous trims. Samples in later cycles use the new ones. Without `cal_load`, the trims do not change.
- R9: While `out_valid` is 0, `out_mv` and `out_frac` hold the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_load | input | 1 | Capture strobe for `cal_byte` |
| cal_byte | input | 8 | Packed trims: [3:0] gain, [7:4] offset |
| in_valid | input | 1 | Raw code qualifier |
| in_raw | input | 10 | Unsigned raw ADC code |
| out_valid | output | 1 | Result qualifier |
| out_mv | output | 16 | Signed whole millivolts |
| out_frac | output | 21 | Signed fraction in millionths of a millivolt |

## Verification
Several properties are checked on every cycle:
- the fraction stays within its range, and its sign agrees with the whole part;
- a positive gain trim never enlarges the corrected count;
- the trims stay stable without a load strobe;
- the fixed three-cycle valid latency.

Exact numeric results can only be shown by the bench scenarios. These cover the nibble decoding, the offset ordering, the truncation of negative values, the same-cycle load ordering and the holding of outputs.

// File: rtl/vbat_cal_pkg.sv
package vbat_cal_pkg;
    localparam int RAW_W  = 10;
    localparam int TRIM_W = 4;
    localparam int CAL_W  = 2 * TRIM_W;
    localparam int ACC_W  = 32;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 21;

    typedef struct packed {
        logic signed [TRIM_W-1:0] zofs;
        logic signed [TRIM_W-1:0] gerr;
    } trim_t;
endpackage

// File: rtl/vbat_trim_reg.sv
module vbat_trim_reg
    import vbat_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_load,
    input  logic [CAL_W-1:0] cal_byte,
    output trim_t            trims
);
    trim_t trim_d, trim_q;

    always_comb begin
        trim_d = trim_q;
        if (cal_load) begin
            trim_d.gerr = cal_byte[TRIM_W-1:0];
            trim_d.zofs = cal_byte[CAL_W-1:TRIM_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trim_q <= '0;
        else        trim_q <= trim_d;
    end

    assign trims = trim_q;

    // R8
    trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_load |=> $stable(trim_q));
endmodule

// File: rtl/vbat_gain_stage.sv
module vbat_gain_stage
    import vbat_cal_pkg::*;
#(
    parameter int GAIN_STEP = 15,
    parameter int GAIN_DIV  = 10000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [RAW_W-1:0]        in_raw,
    input  trim_t                   trims,
    output logic                    c_valid,
    output logic signed [ACC_W-1:0] c_val
);
    typedef struct packed {
        logic                    v;
        logic signed [ACC_W-1:0] a;
        logic signed [ACC_W-1:0] g;
    } s1_t;

    typedef struct packed {
        logic                    v;
        logic signed [ACC_W-1:0] c;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;
    logic signed [ACC_W-1:0] prod;

    always_comb begin
        s1_d   = s1_q;
        s1_d.v = in_valid;
        if (in_valid) begin
            s1_d.a = $signed({{(ACC_W-RAW_W){1'b0}}, in_raw}) - ACC_W'(trims.zofs);
            s1_d.g = GAIN_DIV - ACC_W'(trims.gerr) * GAIN_STEP;
        end
        prod   = s1_q.a * s1_q.g;
        s2_d   = s2_q;
        s2_d.v = s1_q.v;
        if (s1_q.v) s2_d.c = prod / GAIN_DIV;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign c_valid = s2_q.v;
    assign c_val   = s2_q.c;

    // R4
    gain_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.v && s1_q.g <= GAIN_DIV) |=>
        ((s2_q.c < 0 ? -s2_q.c : s2_q.c) <=
         ($past(s1_q.a) < 0 ? -$past(s1_q.a) : $past(s1_q.a))));
endmodule

// File: rtl/vbat_scale_stage.sv
module vbat_scale_stage
    import vbat_cal_pkg::*;
#(
    parameter int LSB_NUM  = 46875,
    parameter int OUT_DIV  = 10000,
    parameter int FRAC_MUL = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     c_valid,
    input  logic signed [ACC_W-1:0]  c_val,
    output logic                     out_valid,
    output logic signed [INT_W-1:0]  out_mv,
    output logic signed [FRAC_W-1:0] out_frac
);
    localparam int FRAC_LIM = OUT_DIV * FRAC_MUL;

    typedef struct packed {
        logic                     v;
        logic signed [INT_W-1:0]  mv;
        logic signed [FRAC_W-1:0] fr;
    } s3_t;

    s3_t s3_d, s3_q;
    logic signed [ACC_W-1:0] m_full, q_full, r_full;

    always_comb begin
        m_full = c_val * LSB_NUM;
        q_full = m_full / OUT_DIV;
        r_full = (m_full % OUT_DIV) * FRAC_MUL;
        s3_d   = s3_q;
        s3_d.v = c_valid;
        if (c_valid) begin
            s3_d.mv = q_full[INT_W-1:0];
            s3_d.fr = r_full[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    assign out_valid = s3_q.v;
    assign out_mv    = s3_q.mv;
    assign out_frac  = s3_q.fr;

    // R5
    frac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ACC_W'(out_frac) < FRAC_LIM && ACC_W'(out_frac) > -FRAC_LIM));

    // R6
    sign_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mv > 0 -> out_frac >= 0) && (out_mv < 0 -> out_frac <= 0)));
endmodule

// File: rtl/vbat_cal_top.sv
module vbat_cal_top
    import vbat_cal_pkg::*;
#(
    parameter int GAIN_STEP = 15,
    parameter int GAIN_DIV  = 10000,
    parameter int LSB_NUM   = 46875,
    parameter int OUT_DIV   = 10000,
    parameter int FRAC_MUL  = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cal_load,
    input  logic [CAL_W-1:0]         cal_byte,
    input  logic                     in_valid,
    input  logic [RAW_W-1:0]         in_raw,
    output logic                     out_valid,
    output logic signed [INT_W-1:0]  out_mv,
    output logic signed [FRAC_W-1:0] out_frac
);
    trim_t                   trims;
    logic                    c_valid;
    logic signed [ACC_W-1:0] c_val;

    vbat_trim_reg u_trim (
        .clk(clk), .rst_n(rst_n), .cal_load(cal_load),
        .cal_byte(cal_byte), .trims(trims)
    );

    vbat_gain_stage #(.GAIN_STEP(GAIN_STEP), .GAIN_DIV(GAIN_DIV)) u_gain (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
        .trims(trims), .c_valid(c_valid), .c_val(c_val)
    );

    vbat_scale_stage #(.LSB_NUM(LSB_NUM), .OUT_DIV(OUT_DIV), .FRAC_MUL(FRAC_MUL)) u_scale (
        .clk(clk), .rst_n(rst_n), .c_valid(c_valid), .c_val(c_val),
        .out_valid(out_valid), .out_mv(out_mv), .out_frac(out_frac)
    );

    logic [1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));
endmodule

// File: tb/vbat_cal_top_tb.sv
module vbat_cal_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_load = 1'b0;
    logic [7:0] cal_byte = '0;
    logic in_valid = 1'b0;
    logic [9:0] in_raw = '0;
    logic out_valid;
    logic signed [15:0] out_mv;
    logic signed [20:0] out_frac;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vbat_cal_top u_dut (
        .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_byte(cal_byte),
        .in_valid(in_valid), .in_raw(in_raw),
        .out_valid(out_valid), .out_mv(out_mv), .out_frac(out_frac)
    );

    // {raw[9:0], cal[7:0]}
    localparam logic [17:0] VEC [8] = '{
        {10'd512,  8'h00}, {10'd1023, 8'h00}, {10'd100, 8'h7F}, {10'd0,   8'h70},
        {10'd1023, 8'h87}, {10'd300,  8'h38}, {10'd5,   8'h77}, {10'd1,   8'h10}
    };

    function automatic int sx4(input logic [3:0] n);
        return n[3] ? int'(n) - 16 : int'(n);
    endfunction

    function automatic void model(input int raw, input logic [7:0] cal,
                                  output int mv, output int fr);
        int a, c, m;
        a  = raw - sx4(cal[7:4]);
        c  = (a * (10000 - sx4(cal[3:0]) * 15)) / 10000;
        m  = c * 46875;
        mv = m / 10000;
        fr = (m % 10000) * 100;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_cal(input logic [7:0] b);
        @(negedge clk); cal_load = 1'b1; cal_byte = b;
        @(negedge clk); cal_load = 1'b0;
    endtask

    // drives one sample, returns at the negedge after the third posedge
    task automatic send(input logic [9:0] r);
        @(negedge clk); in_valid = 1'b1; in_raw = r;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_result(input string req, input int raw, input logic [7:0] cal);
        int mv, fr;
        model(raw, cal, mv, fr);
        check(req, int'(out_valid), 1);
        check(req, int'(out_mv), mv);
        check(req, int'(out_frac), fr);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_mv), 0);
        check("R1", int'(out_frac), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        // R1: trims reset to zero
        send(10'd512);
        check("R1", int'(out_mv), 2400);
        check("R1", int'(out_frac), 0);

        // table walk, R4 R5
        foreach (VEC[i]) begin
            load_cal(VEC[i][7:0]);
            send(VEC[i][17:8]);
            check_result("R4", int'(VEC[i][17:8]), VEC[i][7:0]);
        end

        // R2: signed nibble decode, offset -1
        load_cal(8'hF0); send(10'd0);
        check("R2", int'(out_mv), 4);
        check("R2", int'(out_frac), 687500);
        // R2: gain nibble in low bits, GE=7
        load_cal(8'h07); send(10'd1000);
        check("R2", int'(out_mv), 4635);
        check("R2", int'(out_frac), 937500);
        // R3: offset subtracted first
        load_cal(8'h20); send(10'd10);
        check("R3", int'(out_mv), 37);
        check("R3", int'(out_frac), 500000);
        // R6: negative result truncates toward zero
        load_cal(8'h70); send(10'd0);
        check("R6", int'(out_mv), -32);
        check("R6", int'(out_frac), -812500);
        // R5: fraction of a full-scale corrected code
        load_cal(8'h87); send(10'd1023);
        check("R5", int'(out_mv), 4781);
        check("R5", int'(out_frac), 250000);

        // R9: outputs hold while out_valid is low
        @(negedge clk); @(negedge clk);
        check("R9", int'(out_valid), 0);
        check("R9", int'(out_mv), 4781);
        check("R9", int'(out_frac), 250000);

        // R8: same-cycle load uses old trims, next sample uses new ones
        load_cal(8'h00);
        @(negedge clk); cal_load = 1'b1; cal_byte = 8'h70; in_valid = 1'b1; in_raw = 10'd0;
        @(negedge clk); cal_load = 1'b0; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8", int'(out_mv), 0);
        check("R8", int'(out_frac), 0);
        send(10'd0);
        check("R8", int'(out_mv), -32);
        // R8: later cal_byte changes without strobe are ignored
        @(negedge clk); cal_byte = 8'h00;
        send(10'd0);
        check("R8", int'(out_mv), -32);

        // R7: back-to-back samples, latency of three
        load_cal(8'h00);
        @(negedge clk); in_valid = 1'b1; in_raw = 10'd100;
        @(negedge clk); in_raw = 10'd200;
        check("R7", int'(out_valid), 0);
        @(negedge clk); in_raw = 10'd300;
        check("R7", int'(out_valid), 0);
        @(negedge clk); in_valid = 1'b0;
        check_result("R7", 100, 8'h00);
        @(negedge clk);
        check_result("R7", 200, 8'h00);
        @(negedge clk);
        check_result("R7", 300, 8'h00);
        @(negedge clk);
        check("R7", int'(out_valid), 0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule